// File: doc/BRIEF.md
# Dual-Loop Synthesizer Status, Lock and Powerdown Control

This block is the digital control layer for a synthesizer with two phase-locked loops: a low-frequency intermediate loop (index 0) and a high-frequency loop (index 1). It receives each loop's raw phase-comparator up/down pulses, the outputs of each loop's reference and feedback dividers, and a set of already-latched mode bits. From these it produces one shared status pin, per-loop divider hold signals, charge-pump enable, steering and current-level controls, a fast-lock switch drive, per-loop powerdown flags and an oscillator enable.

Four mode bits pick what the shared status pin carries. It can carry a lock indication for either loop or for both together, a divider output of either loop, or the fast-lock switch, or it can be driven low while it holds the counters of either or both loops in reset. Lock is declared after a run of clean comparison cycles and is withdrawn as soon as one pump pulse is too wide. A loop's powerdown is either immediate, or deferred until that loop's charge pump is quiet. The choice between the two comes from the loop's tri-state bit.

Every output except the oscillator enable is registered. An input change shows at the outputs after the next rising clock edge. A status value that depends on lock state shows one edge after the lock state changes.

Top module: `dual_pll_ctl`

## Requirements
- R1: While `rst` is high on a clock edge, the outputs are `stat_o`=0, `stat_oe_o`=1, `fastlock_o`=0, `pd_o`=00, `div_hold_o`=00, `cp_en_o`=00 and `osc_en_o`=1.
- R2: With `tap_en_i`=00, `stat_sel_i` picks the lock view. Bit 0 means loop 0 and bit 1 means loop 1. The value 00 drives the pin low. The value 01 shows loop 0's lock, 10 shows loop 1's lock, and 11 is high only when both loops are locked.
- R3: With exactly one bit of `tap_en_i` set (bit 0 for loop 0, bit 1 for loop 1), `stat_o` follows that loop's reference divider when `stat_sel_i[0]`=0. It follows that loop's feedback divider when `stat_sel_i[0]`=1. `stat_sel_i[1]` is ignored. The latency is one edge.
- R4: With `tap_en_i`=11 and `stat_sel_i`≠00, each loop whose bit is set in `stat_sel_i` has `div_hold_o` high and `cp_en_o` low. The other loop is unaffected, and `stat_o` is driven low.
- R5: With `tap_en_i`=11 and `stat_sel_i`=00, a high `cur_hi_i[1]` makes `fastlock_o`=1, `stat_oe_o`=1, `stat_o`=0 and `cp_hi_o[1]`=1. A low `cur_hi_i[1]` makes `fastlock_o`=0 and `stat_oe_o`=0 (pin released).
- R6: A loop becomes locked at the LOCK_RUN-th consecutive rising edge of its reference divider in which no pump pulse exceeded PULSE_MAX clocks. While the loop is locked, its lock view is high, except low one edge after any cycle with an up or down pulse present.
- R7: A pump pulse (up or down) that stays high for more than PULSE_MAX clocks clears that loop's lock on the edge it exceeds the limit. The reference cycle that contained it does not count, and a new run of LOCK_RUN clean cycles is needed.
- R8: With `pwdn_i` and `tri_i` both high for a loop, `pd_o` and `div_hold_o` go high and `cp_en_o` goes low at the next edge, regardless of pump activity.
- R9: With `pwdn_i` high and `tri_i` low, `pd_o` stays low while the loop's up or down pulse is high. It rises at the first edge at which both are low.
- R10: With `pwdn_i` low, `pd_o` is low after the next edge.
- R11: `osc_en_o` is low only while both loops have `pd_o` high.
- R12: With `cp_en_o` enabled, `pol_i`=1 passes up to `cp_up_o` and down to `cp_dn_o`, and `pol_i`=0 swaps them. With `tri_i` high, both steering outputs are 0. The latency is one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_up_i | input | 2 | Raw phase-comparator up pulse per loop |
| pd_dn_i | input | 2 | Raw phase-comparator down pulse per loop |
| ref_div_i | input | 2 | Reference divider output per loop |
| fb_div_i | input | 2 | Feedback divider output per loop |
| stat_sel_i | input | 2 | Status selection bits (bit 0 loop 0, bit 1 loop 1) |
| tap_en_i | input | 2 | Divider-tap / special-mode bits (bit 0 loop 0, bit 1 loop 1) |
| pol_i | input | 2 | Comparator polarity per loop |
| tri_i | input | 2 | Charge-pump tri-state request per loop |
| cur_hi_i | input | 2 | Charge-pump high-current request per loop |
| pwdn_i | input | 2 | Powerdown request per loop |
| stat_o | output | 1 | Shared status pin value |
| stat_oe_o | output | 1 | Status pin drive enable (0 = released) |
| fastlock_o | output | 1 | Second damping resistor switch active |
| div_hold_o | output | 2 | Hold dividers of the loop in load/reset state |
| cp_en_o | output | 2 | Charge pump active (0 = tri-stated) |
| cp_up_o | output | 2 | Steered up pulse to charge pump |
| cp_dn_o | output | 2 | Steered down pulse to charge pump |
| cp_hi_o | output | 2 | Charge pump high-current setting |
| pd_o | output | 2 | Loop powered down |
| osc_en_o | output | 1 | Reference oscillator enable |

## Verification
The assertions assume that the mode inputs are quasi-static latched values. They also assume that a pump pulse is a level held for whole clock cycles, and that a reference divider edge is a clean level change sampled on the block clock. The stimulus drives every input only at the falling clock edge and holds it for whole cycles. It keeps the reference high for exactly one cycle per comparison period and restarts with a reset before each directed group. As a result, no lock state carries over from one scenario into the next.

// File: rtl/dpc_pkg.sv
`timescale 1ns/1ps
package dpc_pkg;
  localparam int NLOOP = 2;
  localparam int LP_LO = 0;
  localparam int LP_HI = 1;

  typedef enum logic [2:0] {SRC_LOW, SRC_LOCK, SRC_REF, SRC_FB, SRC_FAST} src_e;

  typedef struct packed {
    src_e             src;
    logic             loop;
    logic [NLOOP-1:0] lmask;
    logic [NLOOP-1:0] crst;
  } mode_t;

  function automatic mode_t decode_mode(input logic [1:0] sel, input logic [1:0] tap);
    mode_t m;
    m.src   = SRC_LOW;
    m.loop  = 1'b0;
    m.lmask = '0;
    m.crst  = '0;
    case (tap)
      2'b00: if (sel != 2'b00) begin
        m.src   = SRC_LOCK;
        m.lmask = sel;
      end
      2'b01: begin
        m.src  = sel[0] ? SRC_FB : SRC_REF;
        m.loop = 1'b0;
      end
      2'b10: begin
        m.src  = sel[0] ? SRC_FB : SRC_REF;
        m.loop = 1'b1;
      end
      default: begin
        if (sel == 2'b00) m.src = SRC_FAST;
        else              m.crst = sel;
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dpc_lock_det.sv
`timescale 1ns/1ps
module dpc_lock_det #(
  parameter int PULSE_MAX = 3,
  parameter int LOCK_RUN  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic pulse_i,
  input  logic ref_i,
  output logic lock_o
);
  localparam int WCW = $clog2(PULSE_MAX + 2);
  localparam int GCW = $clog2(LOCK_RUN + 1);

  logic [WCW-1:0] wid;
  logic [GCW-1:0] good;
  logic           ref_q;
  logic           dirty;
  logic           wide_now;
  logic           ref_rise;

  assign wide_now = pulse_i && (wid == WCW'(PULSE_MAX));
  assign ref_rise = ref_i && !ref_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wid    <= '0;
      good   <= '0;
      ref_q  <= 1'b0;
      dirty  <= 1'b0;
      lock_o <= 1'b0;
    end else begin
      ref_q <= ref_i;
      if (!pulse_i)                    wid <= '0;
      else if (wid != WCW'(PULSE_MAX)) wid <= wid + WCW'(1);
      if (wide_now) begin
        lock_o <= 1'b0;
        good   <= '0;
        dirty  <= 1'b1;
      end else if (ref_rise) begin
        dirty <= 1'b0;
        if (dirty) begin
          good <= '0;
        end else begin
          if (good >= GCW'(LOCK_RUN - 1)) lock_o <= 1'b1;
          if (good != GCW'(LOCK_RUN))     good <= good + GCW'(1);
        end
      end
    end
  end

  // R7: an over-long pulse withdraws lock at the next edge
  a_r7_wide_clears: assert property (@(posedge clk) disable iff (rst)
    wide_now |=> !lock_o);
  // R6: lock is only ever gained on a reference rising edge
  a_r6_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(ref_rise));
endmodule

// File: rtl/dpc_loop.sv
`timescale 1ns/1ps
module dpc_loop (
  input  logic clk,
  input  logic rst,
  input  logic up_i,
  input  logic dn_i,
  input  logic pol_i,
  input  logic tri_i,
  input  logic cur_hi_i,
  input  logic pwdn_i,
  input  logic crst_i,
  output logic pd_o,
  output logic hold_o,
  output logic cp_en_o,
  output logic cp_up_o,
  output logic cp_dn_o,
  output logic cp_hi_o
);
  logic pd_nxt, en_nxt, up_sw, dn_sw;

  always_comb begin
    if (!pwdn_i)                               pd_nxt = 1'b0;
    else if (pd_o || tri_i || (!up_i && !dn_i)) pd_nxt = 1'b1;
    else                                       pd_nxt = 1'b0;
    en_nxt = !tri_i && !crst_i && !pd_nxt;
    up_sw  = pol_i ? up_i : dn_i;
    dn_sw  = pol_i ? dn_i : up_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_o    <= 1'b0;
      hold_o  <= 1'b0;
      cp_en_o <= 1'b0;
      cp_up_o <= 1'b0;
      cp_dn_o <= 1'b0;
      cp_hi_o <= 1'b0;
    end else begin
      pd_o    <= pd_nxt;
      hold_o  <= crst_i || pd_nxt;
      cp_en_o <= en_nxt;
      cp_up_o <= en_nxt && up_sw;
      cp_dn_o <= en_nxt && dn_sw;
      cp_hi_o <= cur_hi_i;
    end
  end

  // R8: immediate powerdown when tri-state requested
  a_r8_async_pd: assert property (@(posedge clk) disable iff (rst)
    (pwdn_i && tri_i) |=> (pd_o && hold_o && !cp_en_o));
  // R9: deferred powerdown waits while the pump is busy
  a_r9_sync_wait: assert property (@(posedge clk) disable iff (rst)
    (pwdn_i && !tri_i && !pd_o && (up_i || dn_i)) |=> !pd_o);
  // R10: wake-up is immediate
  a_r10_wake: assert property (@(posedge clk) disable iff (rst)
    !pwdn_i |=> !pd_o);
  // R12: tri-state silences steering outputs
  a_r12_tri_quiet: assert property (@(posedge clk) disable iff (rst)
    tri_i |=> (!cp_up_o && !cp_dn_o));
endmodule

// File: rtl/dual_pll_ctl.sv
`timescale 1ns/1ps
module dual_pll_ctl
  import dpc_pkg::*;
#(
  parameter int PULSE_MAX = 3,
  parameter int LOCK_RUN  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pd_up_i,
  input  logic [1:0] pd_dn_i,
  input  logic [1:0] ref_div_i,
  input  logic [1:0] fb_div_i,
  input  logic [1:0] stat_sel_i,
  input  logic [1:0] tap_en_i,
  input  logic [1:0] pol_i,
  input  logic [1:0] tri_i,
  input  logic [1:0] cur_hi_i,
  input  logic [1:0] pwdn_i,
  output logic       stat_o,
  output logic       stat_oe_o,
  output logic       fastlock_o,
  output logic [1:0] div_hold_o,
  output logic [1:0] cp_en_o,
  output logic [1:0] cp_up_o,
  output logic [1:0] cp_dn_o,
  output logic [1:0] cp_hi_o,
  output logic [1:0] pd_o,
  output logic       osc_en_o
);
  mode_t            md;
  logic [NLOOP-1:0] locked;
  logic [NLOOP-1:0] lock_view;

  assign md = decode_mode(stat_sel_i, tap_en_i);

  for (genvar k = 0; k < NLOOP; k++) begin : g_loop
    dpc_loop u_loop (
      .clk      (clk),
      .rst      (rst),
      .up_i     (pd_up_i[k]),
      .dn_i     (pd_dn_i[k]),
      .pol_i    (pol_i[k]),
      .tri_i    (tri_i[k]),
      .cur_hi_i (cur_hi_i[k]),
      .pwdn_i   (pwdn_i[k]),
      .crst_i   (md.crst[k]),
      .pd_o     (pd_o[k]),
      .hold_o   (div_hold_o[k]),
      .cp_en_o  (cp_en_o[k]),
      .cp_up_o  (cp_up_o[k]),
      .cp_dn_o  (cp_dn_o[k]),
      .cp_hi_o  (cp_hi_o[k])
    );
    dpc_lock_det #(.PULSE_MAX(PULSE_MAX), .LOCK_RUN(LOCK_RUN)) u_lock (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (div_hold_o[k]),
      .pulse_i (pd_up_i[k] || pd_dn_i[k]),
      .ref_i   (ref_div_i[k]),
      .lock_o  (locked[k])
    );
    assign lock_view[k] = locked[k] && !(pd_up_i[k] || pd_dn_i[k]);
  end

  assign osc_en_o = ~&pd_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o     <= 1'b0;
      stat_oe_o  <= 1'b1;
      fastlock_o <= 1'b0;
    end else begin
      stat_oe_o  <= 1'b1;
      fastlock_o <= 1'b0;
      case (md.src)
        SRC_LOCK: stat_o <= &(lock_view | ~md.lmask);
        SRC_REF:  stat_o <= ref_div_i[md.loop];
        SRC_FB:   stat_o <= fb_div_i[md.loop];
        SRC_FAST: begin
          stat_o     <= 1'b0;
          stat_oe_o  <= cur_hi_i[LP_HI];
          fastlock_o <= cur_hi_i[LP_HI];
        end
        default:  stat_o <= 1'b0;
      endcase
    end
  end

  // R2: all-zero selection drives the pin low
  a_r2_disabled_low: assert property (@(posedge clk) disable iff (rst)
    (tap_en_i == 2'b00 && stat_sel_i == 2'b00) |=> (!stat_o && stat_oe_o));
  // R4: reset mode on loop 0 holds its dividers and stops its pump
  a_r4_reset_lo: assert property (@(posedge clk) disable iff (rst)
    (tap_en_i == 2'b11 && stat_sel_i[0]) |=> (div_hold_o[0] && !cp_en_o[0]));
  // R4: reset mode on loop 1
  a_r4_reset_hi: assert property (@(posedge clk) disable iff (rst)
    (tap_en_i == 2'b11 && stat_sel_i[1]) |=> (div_hold_o[1] && !cp_en_o[1]));
  // R5: fast-lock pulls the pin low with high pump current
  a_r5_fast_drive: assert property (@(posedge clk) disable iff (rst)
    fastlock_o |-> (stat_oe_o && !stat_o && cp_hi_o[1]));
endmodule

// File: tb/dual_pll_ctl_tb.sv
`timescale 1ns/1ps
module dual_pll_ctl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] up = '0, dn = '0, refd = '0, fbd = '0;
  logic [1:0] ssel = '0, tap = '0, pol = '0, tz = '0, chi = '0, pwd = '0;
  logic       stat, stat_oe, fast, osc;
  logic [1:0] hold, cpen, cpup, cpdn, cphi, pdn;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_pll_ctl #(.PULSE_MAX(3), .LOCK_RUN(4)) u_dut (
    .clk(clk), .rst(rst), .pd_up_i(up), .pd_dn_i(dn), .ref_div_i(refd),
    .fb_div_i(fbd), .stat_sel_i(ssel), .tap_en_i(tap), .pol_i(pol),
    .tri_i(tz), .cur_hi_i(chi), .pwdn_i(pwd), .stat_o(stat),
    .stat_oe_o(stat_oe), .fastlock_o(fast), .div_hold_o(hold),
    .cp_en_o(cpen), .cp_up_o(cpup), .cp_dn_o(cpdn), .cp_hi_o(cphi),
    .pd_o(pdn), .osc_en_o(osc));

  // {tap[2], ssel[2], chi_hi, ref[2], fb[2], exp_stat, exp_oe, exp_fast}
  localparam logic [11:0] VEC [0:11] = '{
    12'b00_00_0_00_00_010,
    12'b00_01_0_00_00_010,
    12'b00_11_0_00_00_010,
    12'b01_00_0_01_00_110,
    12'b01_01_0_01_00_010,
    12'b01_01_0_00_01_110,
    12'b10_00_0_10_01_110,
    12'b10_00_0_01_10_010,
    12'b10_11_0_01_10_110,
    12'b11_00_1_00_00_011,
    12'b11_00_0_00_00_000,
    12'b11_01_0_00_00_010
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart();
    rst = 1'b1; up = '0; dn = '0; refd = '0; fbd = '0; ssel = '0; tap = '0;
    pol = '0; tz = '0; chi = '0; pwd = '0;
    tick(2);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic ref_cycle(input int pw);
    refd[0] = 1'b1;
    tick(1);
    refd[0] = 1'b0;
    if (pw > 0) begin
      up[0] = 1'b1;
      tick(pw);
      up[0] = 1'b0;
    end
    tick(7 - pw);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(3);
    chk("R1 stat", {6'd0, stat_oe, stat}, 8'h2);
    chk("R1 fast", {7'd0, fast}, 8'h0);
    chk("R1 pd/hold/cpen", {2'd0, pdn, hold, cpen}, 8'h00);
    chk("R1 osc", {7'd0, osc}, 8'h1);
    rst = 1'b0;
    tick(1);

    // Mode table: R2, R3, R5, R4
    for (int i = 0; i < 12; i++) begin
      tap  = VEC[i][11:10];
      ssel = VEC[i][9:8];
      chi  = {VEC[i][7], 1'b0};
      refd = VEC[i][6:5];
      fbd  = VEC[i][4:3];
      tick(1);
      if (i < 3)       chk("R2 table", {5'd0, stat, stat_oe, fast}, {5'd0, VEC[i][2:0]});
      else if (i < 9)  chk("R3 table", {5'd0, stat, stat_oe, fast}, {5'd0, VEC[i][2:0]});
      else if (i < 11) chk("R5 table", {5'd0, stat, stat_oe, fast}, {5'd0, VEC[i][2:0]});
      else             chk("R4 table", {5'd0, stat, stat_oe, fast}, {5'd0, VEC[i][2:0]});
      if (i == 9) chk("R5 cp_hi", {7'd0, cphi[1]}, 8'h1);
    end

    // R4 counter reset modes
    restart();
    tap = 2'b11; ssel = 2'b01; tick(1);
    chk("R4 lo hold/en", {4'd0, hold, cpen}, {4'd0, 2'b01, 2'b10});
    ssel = 2'b10; tick(1);
    chk("R4 hi hold/en", {4'd0, hold, cpen}, {4'd0, 2'b10, 2'b01});
    ssel = 2'b11; tick(1);
    chk("R4 both hold/en", {4'd0, hold, cpen}, {4'd0, 2'b11, 2'b00});

    // R6 / R7 lock detection on loop 0
    restart();
    ssel = 2'b01;
    for (int c = 0; c < 3; c++) ref_cycle(2);
    chk("R6 not yet locked", {7'd0, stat}, 8'h0);
    ref_cycle(2);
    chk("R6 locked", {7'd0, stat}, 8'h1);
    ssel = 2'b11; tick(1);
    chk("R2 both needs loop1", {7'd0, stat}, 8'h0);
    ssel = 2'b01; tick(1);
    up[0] = 1'b1; tick(1);
    chk("R6 low during pulse", {7'd0, stat}, 8'h0);
    up[0] = 1'b0; tick(1);
    chk("R6 high after short pulse", {7'd0, stat}, 8'h1);
    up[0] = 1'b1; tick(4);
    up[0] = 1'b0; tick(1);
    chk("R7 wide pulse clears", {7'd0, stat}, 8'h0);
    for (int c = 0; c < 4; c++) ref_cycle(1);
    chk("R7 run restarted", {7'd0, stat}, 8'h0);
    ref_cycle(1);
    chk("R7 relocked", {7'd0, stat}, 8'h1);

    // R8..R11 powerdown
    restart();
    tz[1] = 1'b1; pwd[1] = 1'b1; up[1] = 1'b1; tick(1);
    chk("R8 async pd", {2'd0, pdn, hold, cpen}, {2'd0, 2'b10, 2'b10, 2'b01});
    chk("R11 one loop up", {7'd0, osc}, 8'h1);
    up[0] = 1'b1; pwd[0] = 1'b1; tick(2);
    chk("R9 waits for idle", {6'd0, pdn}, 8'h2);
    up[0] = 1'b0; tick(1);
    chk("R9 idle powers down", {6'd0, pdn}, 8'h3);
    chk("R11 osc off", {7'd0, osc}, 8'h0);
    pwd[1] = 1'b0; tick(1);
    chk("R10 wake loop1", {6'd0, pdn}, 8'h1);
    chk("R11 osc back", {7'd0, osc}, 8'h1);
    pwd[0] = 1'b0; tick(1);
    chk("R10 wake loop0", {6'd0, pdn}, 8'h0);

    // R12 polarity steering
    restart();
    pol[0] = 1'b1; up[0] = 1'b1; tick(1);
    chk("R12 pass", {6'd0, cpup[0], cpdn[0]}, 8'h2);
    pol[0] = 1'b0; tick(1);
    chk("R12 swap", {6'd0, cpup[0], cpdn[0]}, 8'h1);
    tz[0] = 1'b1; tick(1);
    chk("R12 tri quiet", {6'd0, cpup[0], cpdn[0]}, 8'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule